// File: doc/BRIEF.md
# Per-Item DMA Channel Arbiter

This block decides which one of several DMA channels may use a shared bus master for its next single data item, one read followed by one write. A channel takes part in the contest when it is enabled and has either a hardware request from its peripheral or a pending software trigger. The two kinds of demand are treated identically.

Each channel carries a two-bit priority. The winner is the candidate with the highest level. When levels are equal, the lowest channel index wins. The winner receives a registered one-hot grant. The grant is held unchanged until the transfer engine pulses the item-done strobe, even if a more urgent channel turns up in the meantime. In the cycle that strobe is seen, the arbiter looks again at the full set of currently active channels and issues the next grant. If no channel is active, the grant is all zeros and the arbiter idles. From idle it grants one cycle after a candidate appears.

Top module: `dma_item_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `grant` is all zeros.
- R2: Channel c is a candidate only when `ch_enable[c]` is 1 and at least one of `hw_req[c]` or `sw_trig[c]` is 1. A disabled channel is never granted.
- R3: A software trigger alone makes a channel a candidate, exactly as a hardware request alone does.
- R4: The priority of channel c is `ch_prio[2c+1:2c]`, encoded 0 = low, 1 = medium, 2 = high, 3 = very high. The candidate with the numerically largest level is granted.
- R5: Among candidates of equal level, the one with the lowest index is granted.
- R6: `grant` has at most one bit set in every cycle.
- R7: While `grant` is non-zero and `item_done` is low, `grant` keeps its value on the next edge, whatever the inputs do.
- R8: When `item_done` is high at a clock edge while a grant is held, the grant after that edge is the R4/R5 choice over the candidates seen at that edge. It may be the same channel, another channel, or zero.
- R9: While `grant` is zero, each clock edge loads the R4/R5 choice over the current candidates, so a grant appears one cycle after a candidate appears. `item_done` has no effect while idle.
- R10: With no candidate at the evaluating edge, `grant` becomes or stays all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_enable | input | NUM_CH | Per-channel enable |
| hw_req | input | NUM_CH | Per-channel hardware peripheral request |
| sw_trig | input | NUM_CH | Per-channel pending software trigger |
| ch_prio | input | 2*NUM_CH | Packed priority levels, two bits per channel |
| item_done | input | 1 | One-cycle strobe: the granted item has finished its write |
| grant | output | NUM_CH | Registered one-hot grant, zero when idle |

## Verification
The hardest situation to reach is a held grant being challenged by a more urgent channel that appears mid-item. In the same cycle, the priority fields and enables change underneath it. Only the value sampled at the done edge may matter. Directed steps raise a very-high channel while a low channel holds the grant for several cycles without a strobe. Then they strobe done and check the handover. A long randomized phase toggles enables, requests, triggers, priority fields and the strobe every cycle. Every cycle it compares the grant against a behavioural model that scans levels from top to bottom.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int PRIO_W     = 2;
    localparam int NUM_LEVELS = 1 << PRIO_W;

    typedef enum logic [PRIO_W-1:0] {
        PRIO_LOW   = 2'd0,
        PRIO_MED   = 2'd1,
        PRIO_HIGH  = 2'd2,
        PRIO_VHIGH = 2'd3
    } prio_e;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;

    function automatic prio_e to_prio(input logic [PRIO_W-1:0] raw);
        return prio_e'(raw);
    endfunction

endpackage

// File: rtl/dma_arb_active.sv
module dma_arb_active #(
    parameter int NUM_CH = 6
) (
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] hw_req,
    input  logic [NUM_CH-1:0] sw_trig,
    output logic [NUM_CH-1:0] active
);
    // Hardware and software demand share one candidate pool.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cand
        assign active[c] = ch_enable[c] & (hw_req[c] | sw_trig[c]);
    end
endmodule

// File: rtl/dma_arb_select.sv
module dma_arb_select
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic [NUM_CH-1:0]        active,
    input  logic [PRIO_W*NUM_CH-1:0] ch_prio,
    output logic [NUM_CH-1:0]        pick
);
    logic [NUM_LEVELS-1:0][NUM_CH-1:0] level_mask;
    logic [NUM_CH-1:0]                 top_mask;

    // Sort candidates into one mask per priority level.
    for (genvar lvl = 0; lvl < NUM_LEVELS; lvl++) begin : g_level
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign level_mask[lvl][c] = active[c] &&
                (to_prio(ch_prio[PRIO_W*c +: PRIO_W]) == prio_e'(lvl));
        end
    end

    // The highest non-empty level overrides the lower ones.
    always_comb begin
        top_mask = '0;
        for (int lvl = 0; lvl < NUM_LEVELS; lvl++) begin
            if (|level_mask[lvl]) top_mask = level_mask[lvl];
        end
    end

    // Isolate the lowest set bit: the lowest index wins a tie.
    assign pick = top_mask & (~top_mask + 1'b1);
endmodule

// File: rtl/dma_arb_grant_reg.sv
module dma_arb_grant_reg
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pick,
    input  logic              item_done,
    output logic [NUM_CH-1:0] grant
);
    arb_state_e state_q;
    logic       load;

    assign load = (state_q == ARB_IDLE) || item_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            grant   <= '0;
        end else if (load) begin
            state_q <= (|pick) ? ARB_BUSY : ARB_IDLE;
            grant   <= pick;
        end
    end

    assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_hold_until_done_R7: assert property (@(posedge clk) disable iff (rst)
        ((grant != '0) && !item_done) |=> $stable(grant));

    assert_idle_stays_idle_R10: assert property (@(posedge clk) disable iff (rst)
        ((grant == '0) && (pick == '0)) |=> (grant == '0));
endmodule

// File: rtl/dma_item_arbiter.sv
module dma_item_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        ch_enable,
    input  logic [NUM_CH-1:0]        hw_req,
    input  logic [NUM_CH-1:0]        sw_trig,
    input  logic [PRIO_W*NUM_CH-1:0] ch_prio,
    input  logic                     item_done,
    output logic [NUM_CH-1:0]        grant
);
    logic [NUM_CH-1:0] active;
    logic [NUM_CH-1:0] pick;

    dma_arb_active #(.NUM_CH(NUM_CH)) u_active (
        .ch_enable (ch_enable),
        .hw_req    (hw_req),
        .sw_trig   (sw_trig),
        .active    (active)
    );

    dma_arb_select #(.NUM_CH(NUM_CH)) u_select (
        .active  (active),
        .ch_prio (ch_prio),
        .pick    (pick)
    );

    dma_arb_grant_reg #(.NUM_CH(NUM_CH)) u_grant (
        .clk       (clk),
        .rst       (rst),
        .pick      (pick),
        .item_done (item_done),
        .grant     (grant)
    );

    // A freshly issued grant must name a channel that was a candidate (R2).
    assert_new_grant_was_active_R2: assert property (@(posedge clk) disable iff (rst)
        ((grant != '0) && ($past(grant) != grant)) |-> (($past(active) & grant) != '0));
endmodule

// File: tb/tb_dma_item_arbiter.sv
module tb_dma_item_arbiter;
    localparam int N = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   ch_enable = '0;
    logic [N-1:0]   hw_req = '0;
    logic [N-1:0]   sw_trig = '0;
    logic [2*N-1:0] ch_prio = '0;
    logic           item_done = 1'b0;
    logic [N-1:0]   grant;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    exp_idx  = -1;
    string tag      = "R1";

    always #4 clk = ~clk;   // 125 MHz

    dma_item_arbiter #(.NUM_CH(N)) dut (
        .clk(clk), .rst(rst), .ch_enable(ch_enable), .hw_req(hw_req),
        .sw_trig(sw_trig), .ch_prio(ch_prio), .item_done(item_done), .grant(grant)
    );

    function automatic int choose();
        for (int p = 3; p >= 0; p--)
            for (int c = 0; c < N; c++)
                if (ch_enable[c] && (hw_req[c] || sw_trig[c]) && (ch_prio[2*c +: 2] == p))
                    return c;
        return -1;
    endfunction

    // Behavioural reference, updated at each rising edge.
    always @(posedge clk) begin
        if (rst) exp_idx <= -1;
        else if (exp_idx < 0 || item_done) exp_idx <= choose();
    end

    function automatic logic [N-1:0] exp_vec();
        logic [N-1:0] v = '0;
        if (exp_idx >= 0) v[exp_idx] = 1'b1;
        return v;
    endfunction

    task automatic step();
        @(negedge clk);
        n_checks++;
        if (grant !== exp_vec()) begin
            n_fail++;
            $display("FAIL %s: grant=%b expected=%b", tag, grant, exp_vec());
        end else if ($countones(grant) > 1) begin
            n_fail++;
            $display("FAIL R6: grant=%b expected at most one bit", grant);
        end
    endtask

    task automatic set_prio(input int c, input int p);
        ch_prio[2*c +: 2] = p[1:0];
    endtask

    initial begin
        fork
            begin
                // R1: reset state
                tag = "R1";
                step(); step();
                hw_req = '1; ch_enable = '0;
                step(); rst = 1'b0; step();
                // R2: nothing enabled, requests ignored
                tag = "R2";
                repeat (3) step();
                hw_req = '0;
                // R3: software trigger alone
                tag = "R3";
                ch_enable = '1; sw_trig[2] = 1'b1;
                step(); step();
                item_done = 1'b1; sw_trig = '0; step(); item_done = 1'b0; step();
                // R4: higher level wins
                tag = "R4";
                set_prio(1, 1); set_prio(4, 3); hw_req[1] = 1'b1; hw_req[4] = 1'b1;
                step(); step();
                // R5: tie broken by lowest index
                tag = "R5";
                set_prio(1, 3); hw_req[3] = 1'b1; set_prio(3, 3);
                item_done = 1'b1; step(); item_done = 1'b0; step();
                // R7: hold against a later very-high request
                tag = "R7";
                hw_req = '0; ch_prio = '0; hw_req[5] = 1'b1;
                item_done = 1'b1; step(); item_done = 1'b0;
                set_prio(0, 3); hw_req[0] = 1'b1; ch_enable[5] = 1'b0;
                repeat (4) step();
                // R8: handover at done
                tag = "R8";
                item_done = 1'b1; step(); item_done = 1'b0; step();
                // R9 / R10: no candidates, done while idle
                tag = "R10";
                hw_req = '0; item_done = 1'b1; step(); step();
                tag = "R9";
                repeat (2) step();
                item_done = 1'b0; sw_trig[3] = 1'b1; step(); step();
                // R6: randomized pressure with model comparison
                tag = "R6";
                for (int i = 0; i < 3000; i++) begin
                    ch_enable = $urandom() | $urandom();
                    hw_req    = $urandom() & $urandom();
                    sw_trig   = $urandom() & $urandom() & $urandom();
                    ch_prio   = $urandom();
                    item_done = ($urandom_range(0, 2) == 0);
                    if (i % 500 == 7) begin rst = 1'b1; tag = "R1"; end
                    else begin rst = 1'b0; tag = "R6"; end
                    step();
                end
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule